// File: doc/BRIEF.md
# Write-back direct-mapped data cache

This block sits between a processor's load/store port and a word-wide memory port. It keeps 2048 one-word lines (8 KB), indexed by address bits 12..2. Each line holds a data word, an address tag (the upper 19 address bits) and a dirty flag. Stores that hit only update the line and mark it dirty. Memory sees the old word only when a later miss evicts that dirty line. Loads and stores may be byte, halfword or word wide, and a per-request flag picks big-endian or little-endian lane numbering.

The processor issues one request at a time. It raises `req_i` while `ready_o` is high, and waits for a one-cycle `done_o` pulse. On a load, `rdata_o` carries the result at that pulse. The cache holds off new requests while it writes a line back, refills a line or forwards an uncached access. Each memory transfer is a level request held with stable address and data until a one-cycle acknowledge. After reset the cache spends one cycle per line writing an unmatchable tag into every entry before it first raises `ready_o`.

Top module: `wb_dcache`

## Requirements
- R1: After reset, `ready_o` stays low for at least 2048 cycles while every line is given the unmatchable tag of address 0xFFFF0000. The first cacheable access to any line afterwards is a miss that performs no memory write.
- R2: Loads are cached only when address bits 31..25 equal 7'h08. Stores are cached only when bits 31..28 equal 4'h1. Any other access goes to memory with its own address, size, direction and data, a load returns the memory word unchanged, and neither counter moves.
- R3: A cacheable load whose line tag matches completes with no memory transfer and increments `hit_cnt_o`.
- R4: A cacheable miss on a clean line increments `miss_cnt_o`, issues exactly one word read at the word-aligned address, and replaces the line's tag.
- R5: A cacheable miss on a dirty line first writes the old word to memory at the address formed from the old tag and the current index, and then refills.
- R6: Every cached store (hit or miss) leaves its line dirty. A store miss refills the word first and then merges the store into it.
- R7: `size_i` encodes 0 = byte, 1 = halfword, 2 = word. The lane offset is address bits 1..0, XORed with 3 when `big_end_i` is 1. A halfword is read from bits starting at (offset & 2)*8 and a byte from bits starting at offset*8, both zero-extended.
- R8: A byte store replicates its low 8 bits into every lane and writes under mask 0xFF shifted by offset*8. A halfword store replicates its low 16 bits and writes under mask 0xFFFF shifted by (offset & 2)*8. A word store replaces the whole word.
- R9: `ready_o` is high only when idle, every accepted request gives exactly one single-cycle `done_o` pulse, and `mem_req_o` stays high with a stable address until `mem_ack_i`.
- R10: `hit_cnt_o` and `miss_cnt_o` count cacheable hits and misses. They change by one in the cycle the access is classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `ready_o` is high |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data, right-justified |
| big_end_i | input | 1 | Big-endian lane numbering when 1 |
| ready_o | output | 1 | Idle, able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Load result, valid with `done_o` |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Memory transfer is a write |
| mem_size_o | output | 2 | Memory transfer width, same encoding as `size_i` |
| mem_addr_o | output | 32 | Memory transfer address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory transfer acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_ack_i` |
| hit_cnt_o | output | 16 | Cacheable hit count |
| miss_cnt_o | output | 16 | Cacheable miss count |

## Verification
Two functions can fall on the same clock edge. When the refill acknowledge arrives for a store miss, the fetched word is merged with the store lanes and the tag with its dirty flag is rewritten, all on that one edge. A dirty eviction then writes the merged value back, so the bench provokes this with store misses of every width. It targets index-aliased addresses, including store-region addresses that loads bypass, and then evicts those lines with loads. Each result is judged against a behavioural model of architectural memory, physical memory and the tag state. The bench compares the logged memory writes, the returned load data and both counters after every access.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_BYP
  } state_e;
endpackage

// File: rtl/wbc_lane.sv
module wbc_lane
  import wbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]                 word_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [$clog2(DATA_W/8)-1:0]       off_i,
  input  logic [1:0]                        size_i,
  input  logic                              big_i,
  output logic [DATA_W-1:0]                 rd_o,
  output logic [DATA_W-1:0]                 merged_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int SH_W   = LANE_W + 3;

  logic [LANE_W-1:0] lane;
  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] mask, rep;

  always_comb begin
    lane = off_i ^ (big_i ? LANE_W'(LANES - 1) : '0);
    case (size_i)
      SZ_BYTE: begin
        sh   = {lane, 3'b000};
        mask = DATA_W'(8'hFF) << sh;
        rep  = {LANES{wdata_i[7:0]}};
      end
      SZ_HALF: begin
        sh   = {lane & ~LANE_W'(1), 3'b000};
        mask = DATA_W'(16'hFFFF) << sh;
        rep  = {(LANES/2){wdata_i[15:0]}};
      end
      default: begin
        sh   = '0;
        mask = '1;
        rep  = wdata_i;
      end
    endcase
    rd_o     = (word_i & mask) >> sh;
    merged_o = (rep & mask) | (word_i & ~mask);
  end
endmodule

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int               IDX_W    = 11,
  parameter int               TAG_W    = 19,
  parameter logic [TAG_W-1:0] INIT_TAG = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [TAG_W-1:0] rtag_o,
  output logic             rdirty_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic             wdirty_i,
  output logic             ready_o
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] dirty_q;
  logic [IDX_W:0]   sweep_q;

  assign ready_o = sweep_q[IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sweep_q <= '0;
    else if (!ready_o) sweep_q <= sweep_q + 1'b1;
  end

  // sweep writes the unmatchable tag, one line per cycle
  always_ff @(posedge clk_i) begin
    if (!ready_o)  tag_q[sweep_q[IDX_W-1:0]] <= INIT_TAG;
    else if (we_i) tag_q[widx_i] <= wtag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dirty_q <= '0;
    else if (we_i) dirty_q[widx_i] <= wdirty_i;
  end

  assign rtag_o   = tag_q[ridx_i];
  assign rdirty_o = dirty_q[ridx_i];

  // R1
  no_write_in_sweep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !we_i);
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int IDX_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
  import wbc_pkg::*;
#(
  parameter int                  ADDR_W    = 32,
  parameter int                  DATA_W    = 32,
  parameter int                  IDX_W     = 11,
  parameter int                  CNT_W     = 16,
  parameter int                  LD_SEL_W  = 7,
  parameter logic [LD_SEL_W-1:0] LD_SEL    = 7'h08,
  parameter int                  ST_SEL_W  = 4,
  parameter logic [ST_SEL_W-1:0] ST_SEL    = 4'h1,
  parameter logic [ADDR_W-1:0]   INIT_WORD = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              big_end_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int               OFF_W    = $clog2(DATA_W / 8);
  localparam int               TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam logic [TAG_W-1:0] INIT_TAG = INIT_WORD[ADDR_W-1 -: TAG_W];

  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [1:0]        size_q;
  logic              we_q, big_q, done_q;
  logic [CNT_W-1:0]  hit_q, miss_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  cur_tag, old_tag;
  logic              old_dirty, tag_ready, cacheable, hit;
  logic [DATA_W-1:0] line_word, lane_word, lane_rd, merged;
  logic              arr_we;
  logic [DATA_W-1:0] arr_wdata;

  assign idx       = addr_q[OFF_W +: IDX_W];
  assign cur_tag   = addr_q[ADDR_W-1 -: TAG_W];
  assign cacheable = we_q ? (addr_q[ADDR_W-1 -: ST_SEL_W] == ST_SEL)
                          : (addr_q[ADDR_W-1 -: LD_SEL_W] == LD_SEL);
  assign hit       = (old_tag == cur_tag);
  assign lane_word = (state_q == ST_FILL) ? mem_rdata_i : line_word;

  assign arr_we    = ((state_q == ST_LOOK) && cacheable && hit && we_q) ||
                     ((state_q == ST_FILL) && mem_ack_i);
  assign arr_wdata = we_q ? merged : mem_rdata_i;

  wbc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .INIT_TAG(INIT_TAG)) i_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ridx_i   (idx),
    .rtag_o   (old_tag),
    .rdirty_o (old_dirty),
    .we_i     (arr_we),
    .widx_i   (idx),
    .wtag_i   (cur_tag),
    .wdirty_i (we_q),
    .ready_o  (tag_ready)
  );

  wbc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_data (
    .clk_i   (clk_i),
    .ridx_i  (idx),
    .rdata_o (line_word),
    .we_i    (arr_we),
    .widx_i  (idx),
    .wdata_i (arr_wdata)
  );

  wbc_lane #(.DATA_W(DATA_W)) i_lane (
    .word_i   (lane_word),
    .wdata_i  (wdata_q),
    .off_i    (addr_q[OFF_W-1:0]),
    .size_i   (size_q),
    .big_i    (big_q),
    .rd_o     (lane_rd),
    .merged_o (merged)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_size_o  = SZ_WORD;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {old_tag, idx, {OFF_W{1'b0}}};
        mem_wdata_o = line_word;
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
      ST_BYP: begin
        mem_req_o   = 1'b1;
        mem_we_o    = we_q;
        mem_size_o  = size_q;
        mem_addr_o  = addr_q;
        mem_wdata_o = wdata_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      big_q   <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      hit_q   <= '0;
      miss_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_INIT: if (tag_ready) state_q <= ST_IDLE;
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          size_q  <= size_i;
          we_q    <= we_i;
          big_q   <= big_end_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!cacheable) begin
            state_q <= ST_BYP;
          end else if (hit) begin
            rdata_q <= lane_rd;
            done_q  <= 1'b1;
            hit_q   <= hit_q + 1'b1;
            state_q <= ST_IDLE;
          end else begin
            miss_q  <= miss_q + 1'b1;
            state_q <= old_dirty ? ST_WB : ST_FILL;
          end
        end
        ST_WB: if (mem_ack_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) begin
          rdata_q <= lane_rd;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_BYP: if (mem_ack_i) begin
          rdata_q <= mem_rdata_i;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign hit_cnt_o  = hit_q;
  assign miss_cnt_o = miss_q;

  // R9
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  wb_then_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) && mem_ack_i |=> mem_req_o && !mem_we_o);

  // R10
  hit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cnt_o != $past(hit_cnt_o) |-> done_o && (hit_cnt_o == CNT_W'($past(hit_cnt_o) + 1'b1)));

  // R10
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o != $past(miss_cnt_o) |-> miss_cnt_o == CNT_W'($past(miss_cnt_o) + 1'b1));
endmodule

// File: tb/test_wb_dcache.sv
`timescale 1ns/1ps
module test_wb_dcache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, big = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] addr = '0, wdata = '0;
  logic        ready, done, mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] rdata, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] hit_cnt, miss_cnt;

  always #2.5 clk = ~clk;

  wb_dcache i_wb_dcache (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .big_end_i(big), .ready_o(ready),
    .done_o(done), .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_size_o(mem_size), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .hit_cnt_o(hit_cnt),
    .miss_cnt_o(miss_cnt)
  );

  int checks = 0, errors = 0;
  bit [31:0] phys [bit [31:0]];
  bit [31:0] ref_phys [bit [31:0]];
  bit [31:0] arch [bit [31:0]];
  int        ref_tag [int];
  bit        ref_dirty [int];
  int        ref_hit = 0, ref_miss = 0;
  bit [31:0] wlog_a [$];
  bit [31:0] wlog_d [$];
  int        lat = 0;

  function automatic bit [31:0] seed_word(bit [31:0] wa);
    return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic bit [31:0] get_phys(bit [31:0] wa);
    return phys.exists(wa) ? phys[wa] : seed_word(wa);
  endfunction
  function automatic bit [31:0] get_ref(bit [31:0] wa);
    return ref_phys.exists(wa) ? ref_phys[wa] : seed_word(wa);
  endfunction
  function automatic bit [31:0] get_arch(bit [31:0] wa);
    return arch.exists(wa) ? arch[wa] : seed_word(wa);
  endfunction

  // R7 lane numbering
  function automatic int lane_of(bit [31:0] a, bit be);
    return int'(a[1:0] ^ (be ? 2'd3 : 2'd0));
  endfunction
  function automatic bit [31:0] extract(bit [31:0] w, bit [31:0] a, bit [1:0] sz, bit be);
    int l = lane_of(a, be);
    if (sz == 2'd0) return (w >> (8 * l)) & 32'hFF;
    if (sz == 2'd1) return (w >> (8 * (l & 2))) & 32'hFFFF;
    return w;
  endfunction
  // R8 store into a word, lane by lane
  function automatic bit [31:0] store_into(bit [31:0] w, bit [31:0] a, bit [1:0] sz, bit [31:0] d, bit be);
    bit [31:0] r = w;
    int l = lane_of(a, be);
    if (sz == 2'd0) r[8*l +: 8] = d[7:0];
    else if (sz == 2'd1) r[8*(l & 2) +: 16] = d[15:0];
    else r = d;
    return r;
  endfunction

  // memory responder: ack two cycles into each request
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat = 0;
    end else if (mem_req) begin
      lat++;
      if (lat == 2) begin
        if (mem_we) begin
          phys[mem_addr >> 2] = mem_wdata;
          wlog_a.push_back(mem_addr);
          wlog_d.push_back(mem_wdata);
        end else begin
          mem_rdata = get_phys(mem_addr >> 2);
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic chk(bit ok, string rq, string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic op(bit w, bit [1:0] sz, bit [31:0] a, bit [31:0] d, bit be, string rq);
    bit        cach = w ? (a[31:28] == 4'h1) : (a[31:25] == 7'h08);
    int        idx = int'((a >> 2) & 32'h7FF);
    int        t = int'(a >> 13);
    int        ot = ref_tag.exists(idx) ? ref_tag[idx] : 32'h7FFF8;
    bit        od = ref_dirty.exists(idx) ? ref_dirty[idx] : 1'b0;
    int        exp_wn = 0;
    bit [31:0] exp_wa = '0, exp_wd = '0, exp_rd;
    int        n = 0;
    int        pulses = 0;
    if (cach) begin
      if (ot == t) begin
        ref_hit++;
        if (w) ref_dirty[idx] = 1'b1;
      end else begin
        ref_miss++;
        if (od) begin
          exp_wn = 1;
          exp_wa = (32'(ot) << 13) | (32'(idx) << 2);
          exp_wd = get_arch(exp_wa >> 2);
          ref_phys[exp_wa >> 2] = exp_wd;
        end
        ref_tag[idx] = t;
        ref_dirty[idx] = w;
      end
      if (w) arch[a >> 2] = store_into(get_arch(a >> 2), a, sz, d, be);
      exp_rd = extract(get_arch(a >> 2), a, sz, be);
    end else begin
      if (w) begin
        exp_wn = 1;
        exp_wa = a;
        exp_wd = d;
        ref_phys[a >> 2] = d;
        arch[a >> 2] = d;
      end
      exp_rd = get_ref(a >> 2);
    end
    wlog_a.delete();
    wlog_d.delete();
    @(negedge clk);
    while (!ready && n < 200) begin @(negedge clk); n++; end
    req = 1'b1; we = w; size = sz; addr = a; wdata = d; big = be;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    if (done) pulses++;
    chk(done == 1'b1, "R9", "done pulse", 32'(done), 32'd1);
    if (!w) chk(rdata == exp_rd, rq, "load data", rdata, exp_rd);
    chk(hit_cnt == 16'(ref_hit), "R10", "hit count", 32'(hit_cnt), 32'(ref_hit));
    chk(miss_cnt == 16'(ref_miss), "R10", "miss count", 32'(miss_cnt), 32'(ref_miss));
    chk(wlog_a.size() == exp_wn, cach ? "R5" : "R2", "memory writes", 32'(wlog_a.size()), 32'(exp_wn));
    if (exp_wn == 1 && wlog_a.size() == 1) begin
      chk(wlog_a[0] == exp_wa, cach ? "R5" : "R2", "write address", wlog_a[0], exp_wa);
      chk(wlog_d[0] == exp_wd, cach ? "R5" : "R2", "write data", wlog_d[0], exp_wd);
    end
    @(negedge clk);
    if (done) pulses++;
    chk(pulses == 1 && ready, "R9", "single pulse then idle", 32'(pulses), 32'd1);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n = 0;
    bit [31:0] rs = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1", "reset outputs", {29'd0, ready, done, mem_req}, 32'd0);
    chk(hit_cnt == 0 && miss_cnt == 0, "R10", "reset counters", {hit_cnt, miss_cnt}, 32'd0);
    rst_n = 1'b1;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
    chk(n >= 2048 && n < 2100, "R1", "init sweep length", 32'(n), 32'd2048);

    op(1'b0, 2'd2, 32'h1000_0000, 0, 1'b1, "R1");            // first access: clean miss
    op(1'b0, 2'd2, 32'h1000_0000, 0, 1'b1, "R3");            // hit
    for (int i = 0; i < 4; i++) begin
      op(1'b0, 2'd0, 32'h1000_0000 + 32'(i), 0, 1'b1, "R7");
      op(1'b0, 2'd0, 32'h1000_0000 + 32'(i), 0, 1'b0, "R7");
    end
    op(1'b0, 2'd1, 32'h1000_0000, 0, 1'b1, "R7");
    op(1'b0, 2'd1, 32'h1000_0002, 0, 1'b0, "R7");
    op(1'b1, 2'd0, 32'h1000_0001, 32'h0000_00A5, 1'b1, "R8"); // store hit byte
    op(1'b0, 2'd2, 32'h1000_0000, 0, 1'b1, "R8");
    op(1'b1, 2'd1, 32'h1000_0002, 32'h0000_BEEF, 1'b0, "R8");
    op(1'b0, 2'd2, 32'h1000_0000, 0, 1'b0, "R8");
    op(1'b0, 2'd2, 32'h1000_2000, 0, 1'b1, "R5");            // evict dirty line 0
    op(1'b0, 2'd2, 32'h1000_0000, 0, 1'b1, "R4");            // clean alias miss
    op(1'b1, 2'd2, 32'h1000_4004, 32'hCAFE_F00D, 1'b1, "R6"); // store miss, word
    op(1'b1, 2'd0, 32'h1000_6008, 32'h0000_0077, 1'b0, "R6"); // store miss, byte
    op(1'b0, 2'd2, 32'h1000_6008, 0, 1'b0, "R6");
    op(1'b0, 2'd2, 32'h1000_8004, 0, 1'b1, "R5");            // evict 0x10004004
    op(1'b0, 2'd2, 32'h1000_a008, 0, 1'b1, "R5");            // evict 0x10006008
    op(1'b0, 2'd0, 32'h2000_0013, 0, 1'b1, "R2");            // uncached load
    op(1'b1, 2'd2, 32'h2000_0020, 32'h1357_9BDF, 1'b1, "R2");
    op(1'b0, 2'd2, 32'h2000_0020, 0, 1'b1, "R2");
    op(1'b1, 2'd2, 32'h1200_0000, 32'h0BAD_CAFE, 1'b1, "R6"); // store-only region is cached
    op(1'b0, 2'd2, 32'h1200_0000, 0, 1'b1, "R2");            // load there bypasses: stale word
    op(1'b0, 2'd2, 32'h1000_0000, 0, 1'b1, "R5");            // evicts 0x12000000
    op(1'b0, 2'd2, 32'h1200_0000, 0, 1'b1, "R2");
    op(1'b0, 2'd1, 32'h11FF_FFFE, 0, 1'b1, "R4");            // top of load region

    for (int i = 0; i < 400; i++) begin
      bit [31:0] a;
      bit [1:0]  sz;
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      sz = (rs[1:0] == 2'd3) ? 2'd2 : rs[1:0];
      a = 32'h1000_0000 | (32'(rs[4:2]) << 13) | (32'(rs[6:5]) << 2);
      if (rs[20:18] == 3'd0) a = a ^ 32'h3000_0000;           // uncached window
      if (sz == 2'd1) a[1:0] = {rs[7], 1'b0};
      else if (sz == 2'd0) a[1:0] = rs[8:7];
      else a[1:0] = 2'd0;
      if (a[31:28] == 4'h2) sz = 2'd2;
      if (sz == 2'd2) a[1:0] = 2'd0;
      op(rs[9], sz, a, rs ^ 32'hA5C3_3C5A, rs[10], rs[9] ? "R6" : "R7");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule